// File: doc/BRIEF.md
# DSP Host Boot Download Sequencer

This block is the host-side engine that brings an attached signal processor from reset to running code over a byte-wide parallel host port. A single start pulse runs the whole bring-up. The block drives the processor's reset line low and presents a set of mode-select values, which it holds steady across the reset release. After a settling wait it issues a boot request. It then polls the processor's control register until the processor signals that a reply is waiting, reads the reply and checks it. Next it streams the code image, waits for and checks the success reply, and acknowledges it. After a programmable settle time it sends the two configuration messages and the start command.

Bus cycles on the host port use a request/acknowledge port with one access outstanding at a time. Image and configuration bytes come from a valid/ready byte stream, and a select output names which of the three streams is being drawn from. All waits are counted in clock cycles. They are derived from a clock-frequency parameter in kilohertz, so the same code serves any clock. When the run ends, either done or err is raised. On an error, err_code gives the step that failed.

Top module: `dsp_boot_seq`

## Requirements
- R1: After reset, busy, done, err, hp_req and src_ready are 0, err_code is 0 and dsp_rst_n is 0.
- R2: A start pulse while not busy drives dsp_rst_n low for at least RSTL_CYC = CLK_KHZ*RSTL_US/1000 cycles, then high. dsp_mode shows mode_in as captured on the start cycle and does not change around the rising edge or for the rest of the run.
- R3: No host-port request is made until at least CLK_KHZ/2 cycles (500 us) after dsp_rst_n rises. The first transfer writes the boot-request code as MSG_BYTES bytes, most significant byte first, to the data address (hp_addr = 0, hp_we = 1).
- R4: Each reply is read only after a control-register read (hp_addr = 1, hp_we = 0) has returned bit RDY_BIT of hp_rdata as 0. The reply is then read as MSG_BYTES data-address reads, assembled first byte most significant. Other bits of the control value are ignored.
- R5: A ready poll that has not seen the flag low after POLL_CYC = 20*CLK_KHZ cycles ends the run with err = 1. err_code is 1 for the first poll and 3 for the second, and no further requests follow.
- R6: If the first reply differs from the boot-start code, the run ends with err_code 2 and no image byte is written.
- R7: After a correct boot-start reply, exactly dl_size image bytes are taken from the stream with src_sel = 0 and written in order to the data address. A dl_size of 0 skips directly to the second poll.
- R8: If the second reply differs from the boot-success code, the run ends with err_code 4 and no acknowledge is written. Otherwise the acknowledge code is written as MSG_BYTES bytes.
- R9: After the last acknowledge byte, no request is made for at least settle_ms*CLK_KHZ cycles.
- R10: The block then writes HW_LEN bytes from src_sel = 1, then SW_LEN bytes from src_sel = 2, then the kickstart code. After that it raises done with busy low.
- R11: Each byte accepted on the stream (src_valid and src_ready both high) is written exactly once, in order. While src_valid is low the block waits, and src_ready is high only while no request is outstanding.
- R12: hp_req, hp_addr, hp_we and hp_wdata stay unchanged until hp_ack. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a boot run (ignored while busy) |
| mode_in | input | MODE_W | Mode-select values for the processor |
| dl_size | input | SIZE_W | Code image length in bytes |
| settle_ms | input | SETTLE_W | Post-boot settle time in milliseconds |
| dsp_rst_n | output | 1 | Processor reset, active low |
| dsp_mode | output | MODE_W | Mode-select values held for the processor |
| hp_req | output | 1 | Host-port access request |
| hp_we | output | 1 | 1 = write, 0 = read |
| hp_addr | output | 1 | 0 = data register, 1 = control register |
| hp_wdata | output | 8 | Write byte |
| hp_ack | input | 1 | Access complete; read byte valid |
| hp_rdata | input | 8 | Read byte |
| src_valid | input | 1 | Stream byte available |
| src_data | input | 8 | Stream byte |
| src_ready | output | 1 | Stream byte accepted when valid |
| src_sel | output | 2 | Stream in use: 0 image, 1 hardware config, 2 software config |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run completed successfully |
| err | output | 1 | Run ended in error |
| err_code | output | 3 | Failing step (1..4) or 0 |

## Verification
The bench attacks the two reply checks and the two poll timeouts separately, because a design that mixed up which step failed would report the wrong err_code or keep writing image bytes after a bad reply. Stalls in the stream and variable acknowledge latency expose any design that drops, repeats or takes bytes early. A design that misjudged a wait would issue its first request before 500 us had passed or cut the settle time short. The zero-length image exposes a counter that wraps and streams 65536 bytes. A stray start pulse in mid-run catches a design that restarts instead of ignoring it, and a control value with every bit set except the ready bit catches one that tests the wrong bit.

// File: rtl/boot_pkg.sv
package boot_pkg;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_RST_LO,
        ST_RST_WAIT,
        ST_WR_REQ,
        ST_POLL1,
        ST_RD1,
        ST_CHK1,
        ST_IMG,
        ST_POLL2,
        ST_RD2,
        ST_CHK2,
        ST_WR_ACK,
        ST_SETTLE,
        ST_WR_HW,
        ST_WR_SW,
        ST_WR_KICK,
        ST_DONE,
        ST_FAIL
    } boot_state_e;

    typedef enum logic [1:0] {
        SRC_IMAGE = 2'd0,
        SRC_HWCFG = 2'd1,
        SRC_SWCFG = 2'd2
    } src_sel_e;

    typedef enum logic [2:0] {
        EC_NONE      = 3'd0,
        EC_TMO_START = 3'd1,
        EC_BAD_START = 3'd2,
        EC_TMO_OK    = 3'd3,
        EC_BAD_OK    = 3'd4
    } err_code_e;

    localparam logic HP_DATA = 1'b0;
    localparam logic HP_CTRL = 1'b1;

    typedef struct packed {
        logic       we;
        logic       addr;
        logic [7:0] data;
    } hp_cmd_t;

    function automatic int unsigned us_to_cyc(input int unsigned khz, input int unsigned us);
        return (khz * us) / 1000;
    endfunction

endpackage

// File: rtl/boot_countdown.sv
module boot_countdown #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         dec,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (ld) begin
            q <= ld_val;
        end else if (dec && (q != '0)) begin
            q <= q - W'(1);
        end
    end

    // R9
    cnt_floor_chk: assert property (@(posedge clk) disable iff (rst)
        (q == '0 && !ld) |=> (q == '0));

endmodule

// File: rtl/boot_msg_shift.sv
module boot_msg_shift #(
    parameter int unsigned BYTES = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ld,
    input  logic [8*BYTES-1:0] ld_word,
    input  logic               shift_out,
    input  logic               shift_in,
    input  logic [7:0]         in_byte,
    output logic [7:0]         out_byte,
    output logic [8*BYTES-1:0] word
);
    localparam int unsigned WW = 8 * BYTES;

    assign out_byte = word[WW-1 -: 8];

    generate
        if (BYTES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst)            word <= '0;
                else if (ld)        word <= ld_word;
                else if (shift_out) word <= '0;
                else if (shift_in)  word <= in_byte;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst)            word <= '0;
                else if (ld)        word <= ld_word;
                else if (shift_out) word <= {word[WW-9:0], 8'h00};
                else if (shift_in)  word <= {word[WW-9:0], in_byte};
            end
        end
    endgenerate

endmodule

// File: rtl/dsp_boot_seq.sv
module dsp_boot_seq
    import boot_pkg::*;
#(
    parameter int unsigned CLK_KHZ   = 250000,
    parameter int unsigned RSTL_US   = 100,
    parameter int unsigned MSG_BYTES = 3,
    parameter int unsigned HW_LEN    = 8,
    parameter int unsigned SW_LEN    = 6,
    parameter int unsigned SIZE_W    = 16,
    parameter int unsigned MODE_W    = 3,
    parameter int unsigned SETTLE_W  = 4,
    parameter int unsigned RDY_BIT   = 0,
    parameter logic [8*MSG_BYTES-1:0] CODE_BOOT_REQ   = 24'h5A_0101,
    parameter logic [8*MSG_BYTES-1:0] CODE_BOOT_START = 24'h5A_0202,
    parameter logic [8*MSG_BYTES-1:0] CODE_BOOT_OK    = 24'h5A_0303,
    parameter logic [8*MSG_BYTES-1:0] CODE_BOOT_ACK   = 24'h5A_0404,
    parameter logic [8*MSG_BYTES-1:0] CODE_KICK       = 24'h5A_0505
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [MODE_W-1:0]   mode_in,
    input  logic [SIZE_W-1:0]   dl_size,
    input  logic [SETTLE_W-1:0] settle_ms,
    output logic                dsp_rst_n,
    output logic [MODE_W-1:0]   dsp_mode,
    output logic                hp_req,
    output logic                hp_we,
    output logic                hp_addr,
    output logic [7:0]          hp_wdata,
    input  logic                hp_ack,
    input  logic [7:0]          hp_rdata,
    input  logic                src_valid,
    input  logic [7:0]          src_data,
    output logic                src_ready,
    output logic [1:0]          src_sel,
    output logic                busy,
    output logic                done,
    output logic                err,
    output logic [2:0]          err_code
);
    localparam int unsigned MSG_W      = 8 * MSG_BYTES;
    localparam int unsigned TMR_W      = 32;
    localparam int unsigned CNT_W      = SIZE_W;
    localparam int unsigned CYC_PER_MS = CLK_KHZ;
    localparam int unsigned RSTL_CYC   = us_to_cyc(CLK_KHZ, RSTL_US);
    localparam int unsigned WAIT_CYC   = us_to_cyc(CLK_KHZ, 500);
    localparam int unsigned POLL_CYC   = CLK_KHZ * 20;

    boot_state_e        st_q, st_d;
    logic               pend_q;
    hp_cmd_t            cmd_q, issue_cmd;
    logic               issue;
    logic [MODE_W-1:0]  mode_q;
    logic               mode_ld;
    logic               rst_n_q, rst_n_d;
    logic [2:0]         ec_q, ec_d;

    logic               tmr_ld;
    logic [TMR_W-1:0]   tmr_val, tmr_q;
    logic               tmr_zero;
    logic               cnt_ld, cnt_dec;
    logic [CNT_W-1:0]   cnt_val, cnt_q;
    logic               cnt_last, cnt_zero;
    logic               sh_ld, sh_out, sh_in;
    logic [MSG_W-1:0]   sh_code, sh_word;
    logic [7:0]         sh_byte;
    logic               ack_ok, src_rdy;

    boot_countdown #(.W(TMR_W)) u_tmr (
        .clk(clk), .rst(rst), .ld(tmr_ld), .ld_val(tmr_val), .dec(1'b1), .q(tmr_q)
    );

    boot_countdown #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .ld(cnt_ld), .ld_val(cnt_val), .dec(cnt_dec), .q(cnt_q)
    );

    boot_msg_shift #(.BYTES(MSG_BYTES)) u_msg (
        .clk(clk), .rst(rst), .ld(sh_ld), .ld_word(sh_code),
        .shift_out(sh_out), .shift_in(sh_in), .in_byte(hp_rdata),
        .out_byte(sh_byte), .word(sh_word)
    );

    assign tmr_zero = (tmr_q == '0);
    assign cnt_zero = (cnt_q == '0);
    assign cnt_last = (cnt_q == CNT_W'(1));
    assign ack_ok   = pend_q && hp_ack;

    always_comb begin
        st_d      = st_q;
        issue     = 1'b0;
        issue_cmd = '{we: 1'b0, addr: HP_DATA, data: 8'h00};
        tmr_ld    = 1'b0;
        tmr_val   = '0;
        cnt_ld    = 1'b0;
        cnt_val   = '0;
        cnt_dec   = 1'b0;
        sh_ld     = 1'b0;
        sh_code   = '0;
        sh_out    = 1'b0;
        sh_in     = 1'b0;
        src_rdy   = 1'b0;
        mode_ld   = 1'b0;
        rst_n_d   = rst_n_q;
        ec_d      = ec_q;

        unique case (st_q)
            ST_IDLE, ST_DONE, ST_FAIL: begin
                if (start) begin
                    st_d    = ST_RST_LO;
                    tmr_ld  = 1'b1;
                    tmr_val = TMR_W'(RSTL_CYC);
                    rst_n_d = 1'b0;
                    mode_ld = 1'b1;
                    ec_d    = EC_NONE;
                end
            end
            ST_RST_LO: begin
                if (tmr_zero) begin
                    st_d    = ST_RST_WAIT;
                    rst_n_d = 1'b1;
                    tmr_ld  = 1'b1;
                    tmr_val = TMR_W'(WAIT_CYC);
                end
            end
            ST_RST_WAIT: begin
                if (tmr_zero) begin
                    st_d    = ST_WR_REQ;
                    sh_ld   = 1'b1;
                    sh_code = CODE_BOOT_REQ;
                    cnt_ld  = 1'b1;
                    cnt_val = CNT_W'(MSG_BYTES);
                end
            end
            ST_WR_REQ, ST_WR_ACK, ST_WR_KICK: begin
                if (!pend_q) begin
                    issue     = 1'b1;
                    issue_cmd = '{we: 1'b1, addr: HP_DATA, data: sh_byte};
                    sh_out    = 1'b1;
                end
                if (ack_ok) begin
                    cnt_dec = 1'b1;
                    if (cnt_last) begin
                        if (st_q == ST_WR_REQ) begin
                            st_d    = ST_POLL1;
                            tmr_ld  = 1'b1;
                            tmr_val = TMR_W'(POLL_CYC);
                        end else if (st_q == ST_WR_ACK) begin
                            st_d    = ST_SETTLE;
                            tmr_ld  = 1'b1;
                            tmr_val = TMR_W'(settle_ms) * TMR_W'(CYC_PER_MS);
                        end else begin
                            st_d = ST_DONE;
                        end
                    end
                end
            end
            ST_POLL1, ST_POLL2: begin
                if (!pend_q) begin
                    issue     = 1'b1;
                    issue_cmd = '{we: 1'b0, addr: HP_CTRL, data: 8'h00};
                end
                if (ack_ok) begin
                    if (!hp_rdata[RDY_BIT]) begin
                        st_d    = (st_q == ST_POLL1) ? ST_RD1 : ST_RD2;
                        cnt_ld  = 1'b1;
                        cnt_val = CNT_W'(MSG_BYTES);
                    end else if (tmr_zero) begin
                        st_d = ST_FAIL;
                        ec_d = (st_q == ST_POLL1) ? EC_TMO_START : EC_TMO_OK;
                    end
                end
            end
            ST_RD1, ST_RD2: begin
                if (!pend_q) begin
                    issue     = 1'b1;
                    issue_cmd = '{we: 1'b0, addr: HP_DATA, data: 8'h00};
                end
                if (ack_ok) begin
                    sh_in   = 1'b1;
                    cnt_dec = 1'b1;
                    if (cnt_last) st_d = (st_q == ST_RD1) ? ST_CHK1 : ST_CHK2;
                end
            end
            ST_CHK1: begin
                if (sh_word != CODE_BOOT_START) begin
                    st_d = ST_FAIL;
                    ec_d = EC_BAD_START;
                end else if (dl_size == '0) begin
                    st_d    = ST_POLL2;
                    tmr_ld  = 1'b1;
                    tmr_val = TMR_W'(POLL_CYC);
                end else begin
                    st_d    = ST_IMG;
                    cnt_ld  = 1'b1;
                    cnt_val = dl_size;
                end
            end
            ST_CHK2: begin
                if (sh_word != CODE_BOOT_OK) begin
                    st_d = ST_FAIL;
                    ec_d = EC_BAD_OK;
                end else begin
                    st_d    = ST_WR_ACK;
                    sh_ld   = 1'b1;
                    sh_code = CODE_BOOT_ACK;
                    cnt_ld  = 1'b1;
                    cnt_val = CNT_W'(MSG_BYTES);
                end
            end
            ST_IMG, ST_WR_HW, ST_WR_SW: begin
                src_rdy = !pend_q && !cnt_zero;
                if (src_rdy && src_valid) begin
                    issue     = 1'b1;
                    issue_cmd = '{we: 1'b1, addr: HP_DATA, data: src_data};
                end
                if (ack_ok) begin
                    cnt_dec = 1'b1;
                    if (cnt_last) begin
                        if (st_q == ST_IMG) begin
                            st_d    = ST_POLL2;
                            tmr_ld  = 1'b1;
                            tmr_val = TMR_W'(POLL_CYC);
                        end else if (st_q == ST_WR_HW) begin
                            st_d    = ST_WR_SW;
                            cnt_ld  = 1'b1;
                            cnt_val = CNT_W'(SW_LEN);
                        end else begin
                            st_d    = ST_WR_KICK;
                            sh_ld   = 1'b1;
                            sh_code = CODE_KICK;
                            cnt_ld  = 1'b1;
                            cnt_val = CNT_W'(MSG_BYTES);
                        end
                    end
                end
            end
            ST_SETTLE: begin
                if (tmr_zero) begin
                    st_d    = ST_WR_HW;
                    cnt_ld  = 1'b1;
                    cnt_val = CNT_W'(HW_LEN);
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            pend_q  <= 1'b0;
            cmd_q   <= '0;
            mode_q  <= '0;
            rst_n_q <= 1'b0;
            ec_q    <= EC_NONE;
        end else begin
            st_q    <= st_d;
            rst_n_q <= rst_n_d;
            ec_q    <= ec_d;
            if (mode_ld) mode_q <= mode_in;
            if (issue) begin
                pend_q <= 1'b1;
                cmd_q  <= issue_cmd;
            end else if (ack_ok) begin
                pend_q <= 1'b0;
            end
        end
    end

    always_comb begin
        unique case (st_q)
            ST_WR_HW: src_sel = SRC_HWCFG;
            ST_WR_SW: src_sel = SRC_SWCFG;
            default:  src_sel = SRC_IMAGE;
        endcase
    end

    assign dsp_rst_n = rst_n_q;
    assign dsp_mode  = mode_q;
    assign hp_req    = pend_q;
    assign hp_we     = cmd_q.we;
    assign hp_addr   = cmd_q.addr;
    assign hp_wdata  = cmd_q.data;
    assign src_ready = src_rdy;
    assign busy      = !(st_q == ST_IDLE || st_q == ST_DONE || st_q == ST_FAIL);
    assign done      = (st_q == ST_DONE);
    assign err       = (st_q == ST_FAIL);
    assign err_code  = ec_q;

    // R12
    hold_req_chk: assert property (@(posedge clk) disable iff (rst)
        (hp_req && !hp_ack) |=> (hp_req && $stable(hp_addr) && $stable(hp_we) && $stable(hp_wdata)));

    // R11
    src_take_chk: assert property (@(posedge clk) disable iff (rst)
        (src_valid && src_ready) |=> (hp_req && hp_we && hp_wdata == $past(src_data)));

    // R2
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dsp_rst_n) |-> $stable(dsp_mode));

    // R5
    fail_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> !hp_req);

endmodule

// File: tb/sim_dsp_boot_seq.sv
`timescale 1ns/1ps
module sim_dsp_boot_seq;
    localparam int KHZ    = 20;
    localparam int RSTL   = 4;      // 200 us at 20 kHz
    localparam int WAITC  = 10;     // 500 us
    localparam int POLLC  = 400;    // 20 ms
    localparam int MSGB   = 3;
    localparam int HWL    = 4;
    localparam int SWL    = 3;
    localparam logic [23:0] C_REQ   = 24'hC1_1A01;
    localparam logic [23:0] C_START = 24'hC2_2B02;
    localparam logic [23:0] C_OK    = 24'hC3_3C03;
    localparam logic [23:0] C_ACK   = 24'hC4_4D04;
    localparam logic [23:0] C_KICK  = 24'hC5_5E05;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [2:0] mode_in = 3'd0;
    logic [15:0] dl_size = 16'd0;
    logic [3:0] settle_ms = 4'd0;
    logic dsp_rst_n, hp_req, hp_we, hp_addr, src_ready, busy, done, err;
    logic [2:0] dsp_mode, err_code;
    logic [7:0] hp_wdata, src_data;
    logic [1:0] src_sel;
    logic hp_ack = 1'b0;
    logic [7:0] hp_rdata = 8'h00;
    logic src_valid = 1'b0;

    always #2 clk = ~clk;

    dsp_boot_seq #(
        .CLK_KHZ(KHZ), .RSTL_US(200), .MSG_BYTES(MSGB), .HW_LEN(HWL), .SW_LEN(SWL),
        .SIZE_W(16), .MODE_W(3), .SETTLE_W(4), .RDY_BIT(0),
        .CODE_BOOT_REQ(C_REQ), .CODE_BOOT_START(C_START), .CODE_BOOT_OK(C_OK),
        .CODE_BOOT_ACK(C_ACK), .CODE_KICK(C_KICK)
    ) u0 (
        .clk(clk), .rst(rst), .start(start), .mode_in(mode_in), .dl_size(dl_size),
        .settle_ms(settle_ms), .dsp_rst_n(dsp_rst_n), .dsp_mode(dsp_mode),
        .hp_req(hp_req), .hp_we(hp_we), .hp_addr(hp_addr), .hp_wdata(hp_wdata),
        .hp_ack(hp_ack), .hp_rdata(hp_rdata), .src_valid(src_valid), .src_data(src_data),
        .src_ready(src_ready), .src_sel(src_sel), .busy(busy), .done(done), .err(err),
        .err_code(err_code)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // reference model state
    logic [7:0] exp_wr[$];
    logic [7:0] srcq[3][$];
    logic [23:0] reply[2];
    int  busy_left[2];
    bit  never[2];
    int  stage, rd_idx, lat, lat_tgt, low_cnt, rise_cyc, ack_cyc, first_poll_cyc;
    int  n_wr, ack_last_idx, settle_cyc;
    bit  ready_shown, prev_rstn, want_first, settle_armed, poll_seen, hs_flag;
    int  hs_sel;
    logic [2:0] cur_mode;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    initial begin : model
        forever begin
            @(negedge clk);
            cyc++;
            if (!rst) begin
                if (dsp_rst_n && !prev_rstn) begin
                    chk(low_cnt >= RSTL, "R2 reset low length", low_cnt, RSTL);
                    chk(dsp_mode == cur_mode, "R2 mode at release", dsp_mode, cur_mode);
                    rise_cyc = cyc;
                    want_first = 1'b1;
                end
                if (!dsp_rst_n) low_cnt++; else low_cnt = 0;
                prev_rstn = dsp_rst_n;
                if (want_first && hp_req) begin
                    chk(cyc - rise_cyc >= WAITC, "R3 wait before first request", cyc - rise_cyc, WAITC);
                    want_first = 1'b0;
                end
                if (settle_armed && hp_req && !hp_ack) begin
                    chk(cyc - ack_cyc >= settle_cyc, "R9 settle wait", cyc - ack_cyc, settle_cyc);
                    settle_armed = 1'b0;
                end
                if (src_ready && hp_req) chk(1'b0, "R11 ready while request outstanding", 1, 0);
                // host-port responder
                if (hp_ack) begin
                    hp_ack = 1'b0;
                end else if (hp_req) begin
                    if (lat < lat_tgt) lat++;
                    else begin
                        lat = 0;
                        lat_tgt = (lat_tgt + 1) % 3;
                        if (hp_we) begin
                            chk(exp_wr.size() > 0 && hp_wdata == exp_wr[0] && hp_addr == 1'b0,
                                "R3 R7 R10 write byte", hp_wdata, exp_wr.size() > 0 ? exp_wr[0] : -1);
                            if (exp_wr.size() > 0) void'(exp_wr.pop_front());
                            n_wr++;
                            if (n_wr == ack_last_idx) begin
                                settle_armed = 1'b1;
                                ack_cyc = cyc;
                            end
                        end else if (hp_addr) begin
                            if (!poll_seen) begin
                                poll_seen = 1'b1;
                                first_poll_cyc = cyc;
                            end
                            if (stage > 1 || never[stage]) hp_rdata = 8'h01;
                            else if (busy_left[stage] > 0) begin
                                busy_left[stage]--;
                                hp_rdata = 8'h01;
                            end else begin
                                hp_rdata = 8'hFE;
                                ready_shown = 1'b1;
                            end
                        end else begin
                            chk(ready_shown, "R4 reply read after ready low", ready_shown, 1);
                            hp_rdata = reply[stage > 1 ? 1 : stage][8*(MSGB-1-rd_idx) +: 8];
                            rd_idx++;
                            if (rd_idx == MSGB) begin
                                rd_idx = 0;
                                ready_shown = 1'b0;
                                poll_seen = 1'b0;
                                stage++;
                            end
                        end
                        hp_ack = 1'b1;
                    end
                end
                // byte source with stalls
                if (hs_flag && srcq[hs_sel].size() > 0) void'(srcq[hs_sel].pop_front());
                if ((cyc % 3) != 0 && srcq[src_sel].size() > 0) begin
                    src_valid = 1'b1;
                    src_data  = srcq[src_sel][0];
                end else begin
                    src_valid = 1'b0;
                    src_data  = 8'h00;
                end
                hs_flag = src_valid && src_ready;
                hs_sel  = src_sel;
            end
        end
    end

    task automatic push_code(input logic [23:0] c);
        for (int i = MSGB - 1; i >= 0; i--) exp_wr.push_back(c[8*i +: 8]);
    endtask

    task automatic run(input string name, input int dsz, input int b1, input int b2,
                       input bit nv1, input bit nv2, input logic [23:0] r1, input logic [23:0] r2,
                       input int stl, input logic [2:0] md, input bit restart, input int exp_ec);
        int limit;
        exp_wr.delete();
        for (int s = 0; s < 3; s++) srcq[s].delete();
        for (int i = 0; i < dsz; i++) srcq[0].push_back(8'((i * 37 + 11) & 255));
        for (int i = 0; i < HWL; i++) srcq[1].push_back(8'(8'hA0 + i));
        for (int i = 0; i < SWL; i++) srcq[2].push_back(8'(8'h60 + i));
        push_code(C_REQ);
        if (r1 == C_START && !nv1) begin
            for (int i = 0; i < dsz; i++) exp_wr.push_back(srcq[0][i]);
            if (r2 == C_OK && !nv2) begin
                push_code(C_ACK);
                for (int i = 0; i < HWL; i++) exp_wr.push_back(srcq[1][i]);
                for (int i = 0; i < SWL; i++) exp_wr.push_back(srcq[2][i]);
                push_code(C_KICK);
            end
        end
        reply[0] = r1; reply[1] = r2;
        busy_left[0] = b1; busy_left[1] = b2;
        never[0] = nv1; never[1] = nv2;
        stage = 0; rd_idx = 0; ready_shown = 1'b0; poll_seen = 1'b0;
        n_wr = 0; ack_last_idx = 2 * MSGB + dsz; settle_armed = 1'b0;
        settle_cyc = stl * KHZ; cur_mode = md;
        dl_size = 16'(dsz); settle_ms = 4'(stl); mode_in = md;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0; mode_in = ~md;
        if (restart) begin
            repeat (12) @(negedge clk);
            start = 1'b1;            // R12: ignored while busy
            @(negedge clk); start = 1'b0;
        end
        limit = 0;
        while (!(done || err) && limit < 5000) begin
            @(negedge clk);
            limit++;
        end
        chk(limit < 5000, {name, " R10 run finishes"}, limit, 5000);
        if (exp_ec == 0) begin
            chk(done && !err && !busy, {name, " R10 done raised"}, done, 1);
        end else begin
            chk(err && !done && !busy, {name, " R5 R6 R8 err raised"}, err, 1);
            if (exp_ec == 1 || exp_ec == 3)
                chk(cyc - first_poll_cyc >= POLLC - 4 && cyc - first_poll_cyc <= POLLC + 8,
                    {name, " R5 timeout length"}, cyc - first_poll_cyc, POLLC);
        end
        chk(err_code == 3'(exp_ec), {name, " R5 R6 R8 err_code"}, err_code, exp_ec);
        chk(dsp_mode == md, {name, " R2 mode held"}, dsp_mode, md);
        repeat (10) @(negedge clk);
        chk(!hp_req, {name, " R5 quiet after end"}, hp_req, 0);
        chk(exp_wr.size() == 0, {name, " R7 R11 all writes seen"}, exp_wr.size(), 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        prev_rstn = 1'b0; lat = 0; lat_tgt = 0; low_cnt = 0; hs_flag = 1'b0; hs_sel = 0;
        want_first = 1'b0; settle_armed = 1'b0; stage = 0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !err, "R1 status idle", {busy, done, err}, 0);
        chk(err_code == 3'd0, "R1 err_code zero", err_code, 0);
        chk(!dsp_rst_n && !hp_req && !src_ready, "R1 outputs quiet", {dsp_rst_n, hp_req, src_ready}, 0);

        run("normal",    5, 2, 1, 0, 0, C_START, C_OK, 3, 3'd5, 1, 0);
        run("no_image",  0, 0, 0, 0, 0, C_START, C_OK, 0, 3'd2, 0, 0);
        run("bad_start", 4, 1, 0, 0, 0, 24'hC2_2B03, C_OK, 1, 3'd1, 0, 2);   // R6
        run("tmo_start", 4, 0, 0, 1, 0, C_START, C_OK, 1, 3'd6, 0, 1);       // R5
        run("bad_ok",    2, 0, 3, 0, 0, C_START, 24'h00_3C03, 1, 3'd3, 0, 4); // R8
        run("tmo_ok",    1, 1, 0, 0, 1, C_START, C_OK, 1, 3'd7, 0, 3);       // R5
        run("again",     7, 3, 2, 0, 0, C_START, C_OK, 2, 3'd4, 0, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule